// File: doc/BRIEF.md
# Thirty-Two-Bit Arithmetic-Logic Unit with Condition Flags

This block is a purely combinational arithmetic-logic unit for a simple integer datapath. A 4-bit operation code selects one of six functions on two 32-bit operands: bitwise AND, bitwise OR, bitwise NOR, addition, subtraction and set-on-less-than. Subtraction reuses the adder by inverting the second operand and forcing the carry-in to one. NOR reuses the AND gate by inverting both operands. Set-on-less-than returns the overflow-corrected sign of the difference in bit 0.

Four condition flags come with every result: zero, sign, carry and two's-complement overflow. A condition evaluator turns these flags into ten relational outcomes, signed and unsigned. Branch and compare logic downstream can then test equality, less-than, less-or-equal, greater-than and greater-or-equal without a second comparator. The relational outputs are meaningful after a subtract operation.

Top module: `alu_core`

## Requirements
- R1: Code 0000 gives the bitwise AND of a and b. Code 0001 gives their bitwise OR.
- R2: Code 0010 gives a + b modulo 2^32. The carry flag equals the carry out of bit 31.
- R3: Code 0110 gives a + ~b + 1, which is a − b modulo 2^32. The carry flag is 1 when no borrow occurs (unsigned a ≥ b) and 0 when a borrow occurs.
- R4: The overflow flag is set on add when a[31] equals b[31] and the result's bit 31 differs from a[31]. It is set on subtract and set-on-less-than when a[31] differs from b[31] and the difference's bit 31 differs from a[31]. For logic operations both carry and overflow read 0.
- R5: Code 0111 gives 1 in bit 0 and zeros in bits 31..1 exactly when a < b as signed numbers. This holds even when a − b overflows. Otherwise the result is all zeros.
- R6: Code 1100 gives the bitwise NOR of a and b.
- R7: For any recognised code, the zero flag is 1 exactly when all 32 result bits are 0, and the sign flag equals result bit 31.
- R8: The signed outputs are derived from the flags with lt = SF^OF, ge = !(SF^OF), gt = !(SF^OF) & !ZF and le = (SF^OF) | ZF. Equality is eq = ZF and ne = !ZF. After subtraction these outputs match the signed relation of a and b.
- R9: The unsigned outputs are derived from the flags with ge = CF, lt = !CF, gt = CF & !ZF and le = !CF | ZF. After subtraction these outputs match the unsigned relation of a and b.
- R10: Any code outside {0000, 0001, 0010, 0110, 0111, 1100} drives the result to 0 and clears all four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 4 | Operation select |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| result | output | 32 | Operation result |
| flag_zero | output | 1 | Result is all zeros |
| flag_sign | output | 1 | Result bit 31 |
| flag_carry | output | 1 | Adder carry out (arithmetic codes only) |
| flag_ovf | output | 1 | Two's-complement overflow (arithmetic codes only) |
| cmp_eq | output | 1 | Equal |
| cmp_ne | output | 1 | Not equal |
| cmp_slt | output | 1 | Signed less-than |
| cmp_sle | output | 1 | Signed less-or-equal |
| cmp_sgt | output | 1 | Signed greater-than |
| cmp_sge | output | 1 | Signed greater-or-equal |
| cmp_ult | output | 1 | Unsigned less-than |
| cmp_ule | output | 1 | Unsigned less-or-equal |
| cmp_ugt | output | 1 | Unsigned greater-than |
| cmp_uge | output | 1 | Unsigned greater-or-equal |

## Verification
The assertions are immediate checks inside combinational blocks, so they assume only that the inputs carry defined 0/1 values. The overflow identity is checked for every operand pair and every carry-in. The zero-difference check assumes that the relational outputs are read after a subtract code. The bench drives fully defined codes and operands one cycle at a time, and it reads the relational outputs against operand truth only under code 0110. Invalid codes are swept exhaustively so that the all-clear rule is observed for each one.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int unsigned CODE_W = 4;

    typedef enum logic [CODE_W-1:0] {
        OP_AND = 4'b0000,
        OP_OR  = 4'b0001,
        OP_ADD = 4'b0010,
        OP_SUB = 4'b0110,
        OP_SLT = 4'b0111,
        OP_NOR = 4'b1100
    } alu_op_e;

    typedef enum logic [1:0] {
        SEL_AND = 2'd0,
        SEL_OR  = 2'd1,
        SEL_SUM = 2'd2,
        SEL_LT  = 2'd3
    } alu_sel_e;

    typedef struct packed {
        logic     valid;
        logic     arith;
        logic     inv_a;
        logic     inv_b;
        alu_sel_e sel;
    } alu_dec_t;

    typedef struct packed {
        logic zero;
        logic sign;
        logic carry;
        logic ovf;
    } alu_flags_t;

    typedef struct packed {
        logic eq;
        logic ne;
        logic slt;
        logic sle;
        logic sgt;
        logic sge;
        logic ult;
        logic ule;
        logic ugt;
        logic uge;
    } alu_cmp_t;

    // Split the code into its inversion controls and output select.
    function automatic alu_dec_t decode_op(input logic [CODE_W-1:0] code);
        alu_dec_t d;
        d.inv_a = code[3];
        d.inv_b = code[2];
        d.sel   = alu_sel_e'(code[1:0]);
        d.valid = 1'b0;
        d.arith = 1'b0;
        case (code)
            OP_AND, OP_OR, OP_NOR:  d.valid = 1'b1;
            OP_ADD, OP_SUB, OP_SLT: begin
                d.valid = 1'b1;
                d.arith = 1'b1;
            end
            default: d.valid = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/alu_ripple_adder.sv
module alu_ripple_adder #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             c_into_msb,
    output logic             c_out
);
    localparam int unsigned MSB = WIDTH - 1;

    logic [WIDTH:0] carry;
    assign carry[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign sum[i]     = x[i] ^ y[i] ^ carry[i];
        assign carry[i+1] = (x[i] & y[i]) | (carry[i] & (x[i] ^ y[i]));
    end

    assign c_into_msb = carry[MSB];
    assign c_out      = carry[WIDTH];

    // The carry-based overflow must agree with the operand-sign rule.
    always_comb begin
        AST_OVF_SIGN_RULE: assert ((c_into_msb ^ c_out) ==
            ((x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]))); // R4
    end

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    output logic [WIDTH-1:0] and_o,
    output logic [WIDTH-1:0] or_o
);
    assign and_o = x & y;
    assign or_o  = x | y;

    // The AND output never holds a bit that the OR output lacks.
    always_comb begin
        AST_AND_WITHIN_OR: assert ((and_o & ~or_o) == '0); // R1
    end

endmodule

// File: rtl/alu_cond_eval.sv
module alu_cond_eval
    import alu_pkg::*;
(
    input  alu_flags_t flags,
    output alu_cmp_t   cmp
);
    logic s_less;

    always_comb begin
        s_less   = flags.sign ^ flags.ovf;
        cmp.eq   = flags.zero;
        cmp.ne   = ~flags.zero;
        cmp.slt  = s_less;
        cmp.sge  = ~s_less;
        cmp.sgt  = ~s_less & ~flags.zero;
        cmp.sle  = s_less | flags.zero;
        cmp.uge  = flags.carry;
        cmp.ult  = ~flags.carry;
        cmp.ugt  = flags.carry & ~flags.zero;
        cmp.ule  = ~flags.carry | flags.zero;
    end

    always_comb begin
        AST_SIGNED_SPLIT:   assert (cmp.slt != cmp.sge);                // R8
        AST_SGT_IMPLIES_GE: assert (!cmp.sgt || (cmp.sge && cmp.ne));   // R8
        AST_UNSIGNED_SPLIT: assert (cmp.ult != cmp.uge);                // R9
        AST_UGT_IMPLIES_GE: assert (!cmp.ugt || (cmp.uge && cmp.ne));   // R9
    end

endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [3:0]       op_code,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [WIDTH-1:0] result,
    output logic             flag_zero,
    output logic             flag_sign,
    output logic             flag_carry,
    output logic             flag_ovf,
    output logic             cmp_eq,
    output logic             cmp_ne,
    output logic             cmp_slt,
    output logic             cmp_sle,
    output logic             cmp_sgt,
    output logic             cmp_sge,
    output logic             cmp_ult,
    output logic             cmp_ule,
    output logic             cmp_ugt,
    output logic             cmp_uge
);
    localparam int unsigned MSB = WIDTH - 1;

    alu_dec_t         dec;
    logic [WIDTH-1:0] a_eff, b_eff;
    logic [WIDTH-1:0] sum, and_v, or_v;
    logic             c_msb, c_out, ovf_raw;
    logic [WIDTH-1:0] res_mux;
    alu_flags_t       flags;
    alu_cmp_t         cmp;

    assign dec   = decode_op(op_code);
    assign a_eff = dec.inv_a ? ~opnd_a : opnd_a;
    assign b_eff = dec.inv_b ? ~opnd_b : opnd_b;

    alu_ripple_adder #(.WIDTH(WIDTH)) u_adder (
        .x          (a_eff),
        .y          (b_eff),
        .cin        (dec.inv_b),
        .sum        (sum),
        .c_into_msb (c_msb),
        .c_out      (c_out)
    );

    alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
        .x     (a_eff),
        .y     (b_eff),
        .and_o (and_v),
        .or_o  (or_v)
    );

    assign ovf_raw = c_msb ^ c_out;

    always_comb begin
        res_mux = '0;
        if (dec.valid) begin
            case (dec.sel)
                SEL_AND: res_mux = and_v;
                SEL_OR:  res_mux = or_v;
                SEL_SUM: res_mux = sum;
                SEL_LT:  res_mux = {{(WIDTH-1){1'b0}}, sum[MSB] ^ ovf_raw};
                default: res_mux = '0;
            endcase
        end
    end

    always_comb begin
        flags.zero  = dec.valid && (res_mux == '0);
        flags.sign  = dec.valid && res_mux[MSB];
        flags.carry = dec.arith && c_out;
        flags.ovf   = dec.arith && ovf_raw;
    end

    alu_cond_eval u_cond (
        .flags (flags),
        .cmp   (cmp)
    );

    assign result     = res_mux;
    assign flag_zero  = flags.zero;
    assign flag_sign  = flags.sign;
    assign flag_carry = flags.carry;
    assign flag_ovf   = flags.ovf;
    assign cmp_eq     = cmp.eq;
    assign cmp_ne     = cmp.ne;
    assign cmp_slt    = cmp.slt;
    assign cmp_sle    = cmp.sle;
    assign cmp_sgt    = cmp.sgt;
    assign cmp_sge    = cmp.sge;
    assign cmp_ult    = cmp.ult;
    assign cmp_ule    = cmp.ule;
    assign cmp_ugt    = cmp.ugt;
    assign cmp_uge    = cmp.uge;

    always_comb begin
        AST_BAD_CODE_CLEAR: assert (dec.valid ||
            (result == '0 && !flag_zero && !flag_sign && !flag_carry && !flag_ovf)); // R10
        AST_LOGIC_NO_ARITH: assert (dec.arith || (!flag_carry && !flag_ovf));        // R4
        AST_SLT_UPPER_ZERO: assert (op_code != OP_SLT ||
            (result[MSB:1] == '0 && !flag_sign));                                    // R5
        AST_SUB_ZERO_NOBORROW: assert (op_code != OP_SUB || !flag_zero ||
            (cmp_uge && cmp_sge && opnd_a == opnd_b));                               // R3
    end

endmodule

// File: tb/alu_core_tb.sv
module alu_core_tb;
    import alu_pkg::*;

    localparam int unsigned W = 32;
    localparam int unsigned WATCHDOG_CYC = 100000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [3:0]   op_code = 4'b0000;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic [W-1:0] result;
    logic         flag_zero, flag_sign, flag_carry, flag_ovf;
    logic         cmp_eq, cmp_ne, cmp_slt, cmp_sle, cmp_sgt, cmp_sge;
    logic         cmp_ult, cmp_ule, cmp_ugt, cmp_uge;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    alu_core #(.WIDTH(W)) u_dut (
        .op_code (op_code), .opnd_a (opnd_a), .opnd_b (opnd_b),
        .result (result), .flag_zero (flag_zero), .flag_sign (flag_sign),
        .flag_carry (flag_carry), .flag_ovf (flag_ovf),
        .cmp_eq (cmp_eq), .cmp_ne (cmp_ne), .cmp_slt (cmp_slt),
        .cmp_sle (cmp_sle), .cmp_sgt (cmp_sgt), .cmp_sge (cmp_sge),
        .cmp_ult (cmp_ult), .cmp_ule (cmp_ule), .cmp_ugt (cmp_ugt),
        .cmp_uge (cmp_uge)
    );

    task automatic check(input string tag, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    // Apply one operation and compare every output with a model built from the requirements.
    task automatic run_op(input string tag, input logic [3:0] code,
                          input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0]   s;
        logic [W-1:0] r;
        logic         valid, arith, of, zf, sf, cf, sl;
        @(negedge clk);
        op_code = code; opnd_a = a; opnd_b = b;
        #2;
        valid = (code == 4'b0000 || code == 4'b0001 || code == 4'b0010 ||
                 code == 4'b0110 || code == 4'b0111 || code == 4'b1100);
        arith = (code == 4'b0010 || code == 4'b0110 || code == 4'b0111);
        if (code == 4'b0010) begin
            s  = {1'b0, a} + {1'b0, b};
            of = (a[W-1] == b[W-1]) && (s[W-1] != a[W-1]);
        end else begin
            s  = {1'b0, a} + {1'b0, ~b} + 1;
            of = (a[W-1] != b[W-1]) && (s[W-1] != a[W-1]);
        end
        case (code)
            4'b0000: r = a & b;
            4'b0001: r = a | b;
            4'b0010: r = s[W-1:0];
            4'b0110: r = s[W-1:0];
            4'b0111: r = ($signed(a) < $signed(b)) ? 1 : 0;
            4'b1100: r = ~(a | b);
            default: r = '0;
        endcase
        zf = valid && (r == '0);
        sf = valid && r[W-1];
        cf = arith && s[W];
        of = arith && of;
        sl = sf ^ of;
        check(tag, "result", result, r);
        check(tag, "zero",   W'(flag_zero),  W'(zf));
        check(tag, "sign",   W'(flag_sign),  W'(sf));
        check(tag, "carry",  W'(flag_carry), W'(cf));
        check(tag, "ovf",    W'(flag_ovf),   W'(of));
        check(tag, "cmp_eq/ne R8", W'({cmp_eq, cmp_ne}), W'({zf, !zf}));
        check(tag, "signed cmps R8", W'({cmp_slt, cmp_sge, cmp_sgt, cmp_sle}),
              W'({sl, !sl, !sl && !zf, sl || zf}));
        check(tag, "unsigned cmps R9", W'({cmp_ult, cmp_uge, cmp_ugt, cmp_ule}),
              W'({!cf, cf, cf && !zf, !cf || zf}));
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        #2;
        check("R1 reset", "result", result, '0);
        check("R7 reset", "zero", W'(flag_zero), W'(1'b1));
    endtask

    task automatic t_logic_ops();
        run_op("R1 and", 4'b0000, 32'hF0F0_1234, 32'hFF00_00FF);
        run_op("R1 or",  4'b0001, 32'h0F0F_0000, 32'h0000_A5A5);
        run_op("R1 and-zero", 4'b0000, 32'hAAAA_AAAA, 32'h5555_5555);
        run_op("R6 nor", 4'b1100, 32'h0000_FFFF, 32'h00FF_0000);
        run_op("R6 nor-zero", 4'b1100, 32'hFFFF_FFFF, 32'h0);
        run_op("R7 or-sign", 4'b0001, 32'h8000_0000, 32'h1);
    endtask

    task automatic t_add();
        run_op("R2 add", 4'b0010, 32'd1000, 32'd2345);
        run_op("R2 add-wrap", 4'b0010, 32'hFFFF_FFFF, 32'h1);
        run_op("R4 add-posovf", 4'b0010, 32'h7FFF_FFFF, 32'h1);
        run_op("R4 add-negovf", 4'b0010, 32'h8000_0000, 32'h8000_0000);
        run_op("R4 add-mixed", 4'b0010, 32'h7FFF_FFFF, 32'h8000_0000);
    endtask

    task automatic t_sub();
        run_op("R3 sub-equal", 4'b0110, 32'h1234_5678, 32'h1234_5678);
        run_op("R3 sub-borrow", 4'b0110, 32'd5, 32'd9);
        run_op("R3 sub-noborrow", 4'b0110, 32'd9, 32'd5);
        run_op("R4 sub-ovf", 4'b0110, 32'h8000_0000, 32'h1);
        run_op("R4 sub-ovf2", 4'b0110, 32'h0, 32'h8000_0000);
    endtask

    task automatic t_slt();
        run_op("R5 slt-neg", 4'b0111, 32'hFFFF_FFFF, 32'h1);
        run_op("R5 slt-pos", 4'b0111, 32'h1, 32'hFFFF_FFFF);
        run_op("R5 slt-ovf-true", 4'b0111, 32'h8000_0000, 32'h1);
        run_op("R5 slt-ovf-false", 4'b0111, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        run_op("R5 slt-equal", 4'b0111, 32'd42, 32'd42);
    endtask

    // After subtract, relational outputs must match the operands' true ordering.
    task automatic t_relations();
        logic [W-1:0] av [6];
        logic [W-1:0] bv [6];
        av = '{32'd3, 32'd7, 32'hFFFF_FFFE, 32'h8000_0000, 32'h7FFF_FFFF, 32'd10};
        bv = '{32'd7, 32'd3, 32'd2, 32'h7FFF_FFFF, 32'h8000_0000, 32'd10};
        for (int i = 0; i < 6; i++) begin
            run_op("R8 R9 rel", 4'b0110, av[i], bv[i]);
            check("R8 signed truth", "lt/le/gt/ge",
                  W'({cmp_slt, cmp_sle, cmp_sgt, cmp_sge}),
                  W'({$signed(av[i]) < $signed(bv[i]), $signed(av[i]) <= $signed(bv[i]),
                      $signed(av[i]) > $signed(bv[i]), $signed(av[i]) >= $signed(bv[i])}));
            check("R9 unsigned truth", "lt/le/gt/ge",
                  W'({cmp_ult, cmp_ule, cmp_ugt, cmp_uge}),
                  W'({av[i] < bv[i], av[i] <= bv[i], av[i] > bv[i], av[i] >= bv[i]}));
            check("R8 eq truth", "eq", W'(cmp_eq), W'(av[i] == bv[i]));
        end
    endtask

    task automatic t_bad_codes();
        for (int c = 0; c < 16; c++) begin
            if (!(c == 0 || c == 1 || c == 2 || c == 6 || c == 7 || c == 12)) begin
                run_op("R10 bad-code", 4'(c), 32'h8000_0001, 32'h8000_0001);
                check("R10 bad-code flags", "all flags",
                      W'({flag_zero, flag_sign, flag_carry, flag_ovf}), '0);
            end
        end
    endtask

    initial begin
        for (int i = 0; i < WATCHDOG_CYC; i++) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (2) @(posedge clk);
        rst = 1'b0;
        t_reset_state();
        t_logic_ops();
        t_add();
        t_sub();
        t_slt();
        t_relations();
        t_bad_codes();
        finish_run();
    end

endmodule